// File: doc/BRIEF.md
# Entropy Request Control Register Bank

This block is the software-facing register bank of an entropy request peripheral. A simple synchronous register port reaches it: one request strobe, a write flag, a word index and 32-bit write data. Reads return data combinationally in the same cycle. The bank holds two interrupt sources, with their state, enable and test registers. It also holds an alert test register, a lock register that can only be cleared, and a 16-bit control word. The control word is split into four 4-bit redundant boolean fields. A recoverable-alert status register and an error-injection register complete the bank.

Each control field is decoded to a single bit for the command logic downstream. A field holding any encoding other than true (4'h6) or false (4'h9) is treated as false. Such a field also sets a sticky status bit that software clears by writing zero. An accepted control write that carries an illegal field raises a one-cycle recoverable alert. An event reporting a repeated bus value also raises that alert and sets its own sticky status bit. A write to the error-injection register drives a one-cycle one-hot pulse on the error line selected by the written index.

Top module: `entropy_ctl_regs`

Word indices: 0 interrupt state, 1 interrupt enable, 2 interrupt test, 3 alert test, 4 lock, 5 control, 6 recoverable alert status, 7 error-injection select.

## Requirements
- R1: After reset, the registers read as follows: interrupt state 0, interrupt enable 0, lock 1, control 0x9999, alert status 0, error select 0. The interrupt, alert and error-pulse outputs are 0.
- R2: Interrupt state bit 0 (command done) and bit 1 (fatal) are set by their hardware event inputs and cleared by writing 1 to them. An event in the same cycle as a clearing write leaves the bit set.
- R3: Writing 1 to bit k of the interrupt test register (index 2) sets interrupt state bit k at the next clock edge.
- R4: Output line intr_o[k] equals interrupt state bit k AND interrupt enable bit k.
- R5: A write of 1 to alert test bit 0 gives a one-cycle pulse on alert_recov_o one clock edge after the write. A write of 1 to alert test bit 1 does the same on alert_fatal_o.
- R6: Lock bit 0 resets to 1 and is cleared by writing 0. Writing 1 to it never sets it again.
- R7: While the lock bit is 0, writes to the control register leave its value unchanged.
- R8: The control fields are, from bit 0 upward in 4-bit steps: enable, boot request, auto request and command FIFO reset. ctrl_bool_o[i] is 1 exactly when field i holds 4'h6. It is 0 for 4'h9 and for every illegal value.
- R9: While control field i holds a value other than 4'h6 or 4'h9, alert status bit i (bits 0 to 3) is set. Writing 0 to the bit clears it once the field is legal. If the field is still illegal, setting wins over the clearing write.
- R10: An accepted control write that carries at least one illegal field gives a one-cycle alert_recov_o pulse one clock edge later. A write with all fields legal gives none.
- R11: A pulse on bus_repeat_evt_i sets alert status bit 12, which is cleared by writing 0, and gives an alert_recov_o pulse one edge later.
- R12: A write of value n to the error select register (index 7, bits 4:0) drives err_force_o = 1<<n for exactly the one cycle after the write edge. The register reads back n.
- R13: Reserved and write-only bits read as 0: the upper bits of every register, the whole of indices 2 and 3, and alert status bits 11:4 and 31:13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| cmd_done_evt_i | input | 1 | Hardware event: command request done |
| fatal_evt_i | input | 1 | Hardware event: fatal error |
| bus_repeat_evt_i | input | 1 | Hardware event: repeated bus value seen |
| intr_o | output | 2 | Interrupt lines, state AND enable |
| alert_recov_o | output | 1 | Recoverable alert pulse |
| alert_fatal_o | output | 1 | Fatal alert pulse |
| ctrl_bool_o | output | 4 | Decoded control fields, illegal treated as false |
| err_force_o | output | 32 | One-hot forced error pulse |

## Verification
Two pairs of updates can land on the same clock edge. One is a hardware interrupt event arriving on the edge of a write-one-to-clear. The other is an illegal control field still present on the edge of a write-zero-to-clear to its status bit. The bench raises the event input during the clearing write, and separately leaves the field illegal while writing zero to the status register. It then reads the bit back and expects it to remain 1. Around these cases, every 4-bit value of every control field is swept, together with all state/enable combinations and every error-select index.

// File: rtl/ectl_pkg.sv
package ectl_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned FIELD_W     = 4;
  localparam int unsigned CTRL_FIELDS = 4;
  localparam int unsigned CTRL_W      = FIELD_W * CTRL_FIELDS;
  localparam int unsigned N_INTR      = 2;
  localparam int unsigned BUS_STS_BIT = 12;

  localparam logic [FIELD_W-1:0] MB_TRUE  = 4'h6;
  localparam logic [FIELD_W-1:0] MB_FALSE = 4'h9;
  localparam logic [CTRL_W-1:0]  CTRL_RST = {CTRL_FIELDS{MB_FALSE}};

  typedef enum logic [2:0] {
    IX_ISTATE  = 3'd0,
    IX_IENABLE = 3'd1,
    IX_ITEST   = 3'd2,
    IX_ATEST   = 3'd3,
    IX_LOCK    = 3'd4,
    IX_CTRL    = 3'd5,
    IX_RSTS    = 3'd6,
    IX_ERRSEL  = 3'd7
  } reg_ix_e;

  function automatic logic mb_legal(input logic [FIELD_W-1:0] v);
    return (v == MB_TRUE) || (v == MB_FALSE);
  endfunction

  function automatic logic mb_to_bool(input logic [FIELD_W-1:0] v);
    return v == MB_TRUE;
  endfunction

  function automatic logic word_has_illegal(input logic [CTRL_W-1:0] w);
    logic bad;
    bad = 1'b0;
    for (int i = 0; i < CTRL_FIELDS; i++) begin
      bad = bad | !mb_legal(w[i*FIELD_W +: FIELD_W]);
    end
    return bad;
  endfunction
endpackage

// File: rtl/ectl_mubi_chk.sv
module ectl_mubi_chk
  import ectl_pkg::*;
(
  input  logic [FIELD_W-1:0] field_i,
  output logic               bool_o,
  output logic               illegal_o
);
  always_comb begin
    bool_o    = mb_to_bool(field_i);
    illegal_o = !mb_legal(field_i);
  end
endmodule

// File: rtl/ectl_intr.sv
module ectl_intr #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set_i,
  input  logic         clr_wr_i,
  input  logic         test_wr_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] state_o,
  output logic [N-1:0] enable_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] state_q, enable_q, set_v, clr_v;

  always_comb begin
    clr_v = clr_wr_i  ? wdata_i : '0;
    set_v = hw_set_i | (test_wr_i ? wdata_i : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= '0;
      enable_q <= '0;
    end else begin
      state_q <= (state_q & ~clr_v) | set_v;
      if (en_wr_i) enable_q <= wdata_i;
    end
  end

  assign state_o  = state_q;
  assign enable_o = enable_q;
  assign irq_o    = state_q & enable_q;

  // R2 / R3: any set source present on an edge leaves the bit set
  p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((state_q & $past(set_v)) == $past(set_v)));

  // R4: a line is only raised if its enable was written or held
  p_irq_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> (|enable_q));
endmodule

// File: rtl/ectl_err_inject.sv
module ectl_err_inject #(
  parameter int unsigned SEL_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [SEL_W-1:0]      sel_i,
  output logic [SEL_W-1:0]      sel_o,
  output logic [(1<<SEL_W)-1:0] force_o
);
  localparam int unsigned LINES = 1 << SEL_W;

  logic [SEL_W-1:0] sel_q;
  logic [LINES-1:0] force_q;

  function automatic logic [LINES-1:0] decode_sel(input logic [SEL_W-1:0] s);
    logic [LINES-1:0] v;
    for (int k = 0; k < LINES; k++) v[k] = (s == SEL_W'(k));
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      force_q <= '0;
    end else begin
      force_q <= wr_i ? decode_sel(sel_i) : '0;
      if (wr_i) sel_q <= sel_i;
    end
  end

  assign sel_o   = sel_q;
  assign force_o = force_q;

  p_force_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(force_q));

  p_force_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|force_q) |-> $past(wr_i));
endmodule

// File: rtl/entropy_ctl_regs.sv
module entropy_ctl_regs
  import ectl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned ERR_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic                  cmd_done_evt_i,
  input  logic                  fatal_evt_i,
  input  logic                  bus_repeat_evt_i,
  output logic [N_INTR-1:0]     intr_o,
  output logic                  alert_recov_o,
  output logic                  alert_fatal_o,
  output logic [CTRL_FIELDS-1:0] ctrl_bool_o,
  output logic [(1<<ERR_W)-1:0] err_force_o
);
  localparam int unsigned N_REGS = 8;

  // named write strobes, one per register index
  logic [N_REGS-1:0] wr_hit;
  for (genvar r = 0; r < N_REGS; r++) begin : g_dec
    assign wr_hit[r] = req_i && we_i && (addr_i == ADDR_W'(r));
  end

  logic wr_lock, wr_ctrl, wr_rsts, wr_atest, ctrl_accept;
  assign wr_lock     = wr_hit[IX_LOCK];
  assign wr_ctrl     = wr_hit[IX_CTRL];
  assign wr_rsts     = wr_hit[IX_RSTS];
  assign wr_atest    = wr_hit[IX_ATEST];

  // lock (write zero to clear)
  logic lock_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     lock_q <= 1'b1;
    else if (wr_lock && !wdata_i[0]) lock_q <= 1'b0;
  end
  assign ctrl_accept = wr_ctrl && lock_q;

  // control word
  logic [CTRL_W-1:0] ctrl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ctrl_q <= CTRL_RST;
    else if (ctrl_accept) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  logic [CTRL_FIELDS-1:0] fld_illegal;
  for (genvar f = 0; f < CTRL_FIELDS; f++) begin : g_fld
    ectl_mubi_chk u_chk (
      .field_i   (ctrl_q[f*FIELD_W +: FIELD_W]),
      .bool_o    (ctrl_bool_o[f]),
      .illegal_o (fld_illegal[f])
    );
  end

  // recoverable alert status: sticky, write zero to clear, set wins
  logic [CTRL_FIELDS-1:0] sts_fld_q;
  logic                   sts_bus_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_fld_q <= '0;
      sts_bus_q <= 1'b0;
    end else begin
      sts_fld_q <= (sts_fld_q & ~(wr_rsts ? ~wdata_i[CTRL_FIELDS-1:0] : '0))
                   | fld_illegal;
      sts_bus_q <= (sts_bus_q & !(wr_rsts && !wdata_i[BUS_STS_BIT]))
                   | bus_repeat_evt_i;
    end
  end

  // alert pulses
  logic recov_src, alert_recov_q, alert_fatal_q;
  assign recov_src = (wr_atest && wdata_i[0])
                   || (ctrl_accept && word_has_illegal(wdata_i[CTRL_W-1:0]))
                   || bus_repeat_evt_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alert_recov_q <= 1'b0;
      alert_fatal_q <= 1'b0;
    end else begin
      alert_recov_q <= recov_src;
      alert_fatal_q <= wr_atest && wdata_i[1];
    end
  end
  assign alert_recov_o = alert_recov_q;
  assign alert_fatal_o = alert_fatal_q;

  // interrupts
  logic [N_INTR-1:0] istate, ienable;
  ectl_intr #(.N(N_INTR)) u_intr (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_set_i  ({fatal_evt_i, cmd_done_evt_i}),
    .clr_wr_i  (wr_hit[IX_ISTATE]),
    .test_wr_i (wr_hit[IX_ITEST]),
    .en_wr_i   (wr_hit[IX_IENABLE]),
    .wdata_i   (wdata_i[N_INTR-1:0]),
    .state_o   (istate),
    .enable_o  (ienable),
    .irq_o     (intr_o)
  );

  // error injection
  logic [ERR_W-1:0] err_sel;
  ectl_err_inject #(.SEL_W(ERR_W)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_hit[IX_ERRSEL]),
    .sel_i   (wdata_i[ERR_W-1:0]),
    .sel_o   (err_sel),
    .force_o (err_force_o)
  );

  // read mux, reserved bits zero
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(IX_ISTATE):  rdata_o[N_INTR-1:0] = istate;
      ADDR_W'(IX_IENABLE): rdata_o[N_INTR-1:0] = ienable;
      ADDR_W'(IX_LOCK):    rdata_o[0] = lock_q;
      ADDR_W'(IX_CTRL):    rdata_o[CTRL_W-1:0] = ctrl_q;
      ADDR_W'(IX_RSTS): begin
        rdata_o[CTRL_FIELDS-1:0] = sts_fld_q;
        rdata_o[BUS_STS_BIT]     = sts_bus_q;
      end
      ADDR_W'(IX_ERRSEL):  rdata_o[ERR_W-1:0] = err_sel;
      default:             rdata_o = '0;
    endcase
  end

  // R6: once cleared, the lock never returns
  p_lock_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> !lock_q);

  // R7: a control write while locked leaves the word unchanged
  p_lock_holds_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !lock_q) |=> (ctrl_q == $past(ctrl_q)));

  // R9: an illegal field is reflected in its status bit after the edge
  p_sticky_fld_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|fld_illegal) |=> ((sts_fld_q & $past(fld_illegal)) == $past(fld_illegal)));

  // R5: fatal alert only follows a test write
  p_fatal_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alert_fatal_o |-> $past(wr_atest));

  // R8: a decoded true is never also flagged illegal
  p_bool_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_bool_o & fld_illegal) == '0);
endmodule

// File: tb/sim_entropy_ctl_regs.sv
`timescale 1ns/1ps
module sim_entropy_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        cmd_done_evt_i = 1'b0, fatal_evt_i = 1'b0, bus_repeat_evt_i = 1'b0;
  logic [1:0]  intr_o;
  logic        alert_recov_o, alert_fatal_o;
  logic [3:0]  ctrl_bool_o;
  logic [31:0] err_force_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  entropy_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cmd_done_evt_i(cmd_done_evt_i),
    .fatal_evt_i(fatal_evt_i), .bus_repeat_evt_i(bus_repeat_evt_i),
    .intr_o(intr_o), .alert_recov_o(alert_recov_o), .alert_fatal_o(alert_fatal_o),
    .ctrl_bool_o(ctrl_bool_o), .err_force_o(err_force_o)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
    end
  endtask

  task automatic chk_eq(input string rq, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, rq, act, exp);
  endtask

  // write spans one rising edge; returns at the following falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  function automatic logic exp_legal(input logic [3:0] v);
    return (v == 4'd6) || (v == 4'd9);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(3'd0, d); chk_eq("R1 istate", d, 32'h0);
    rd(3'd1, d); chk_eq("R1 ienable", d, 32'h0);
    rd(3'd4, d); chk_eq("R1 lock", d, 32'h1);
    rd(3'd5, d); chk_eq("R1 ctrl", d, 32'h9999);
    rd(3'd6, d); chk_eq("R1 rsts", d, 32'h0);
    rd(3'd7, d); chk_eq("R1 errsel", d, 32'h0);
    chk_eq("R1 outputs", {intr_o, alert_recov_o, alert_fatal_o, err_force_o[27:0]}, 32'h0);
    chk_eq("R1 bools", {28'h0, ctrl_bool_o}, 32'h0);

    // R3 / R4: sweep state x enable
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 4; e++) begin
        wr(3'd0, 32'h3);
        wr(3'd2, 32'(s));
        wr(3'd1, 32'(e));
        rd(3'd0, d); chk_eq("R3 test sets state", d, 32'(s));
        chk_eq("R4 intr lines", {30'h0, intr_o}, 32'(s & e));
      end
    end

    // R2: hardware events set, W1C clears
    wr(3'd0, 32'h3);
    @(negedge clk); cmd_done_evt_i = 1'b1;
    @(negedge clk); cmd_done_evt_i = 1'b0;
    rd(3'd0, d); chk_eq("R2 cmd event sets bit0", d, 32'h1);
    @(negedge clk); fatal_evt_i = 1'b1;
    @(negedge clk); fatal_evt_i = 1'b0;
    rd(3'd0, d); chk_eq("R2 fatal event sets bit1", d, 32'h3);
    wr(3'd0, 32'h2);
    rd(3'd0, d); chk_eq("R2 W1C bit1 only", d, 32'h1);
    // collision: event on the clearing edge
    @(negedge clk); cmd_done_evt_i = 1'b1;
    wr(3'd0, 32'h1);
    cmd_done_evt_i = 1'b0;
    rd(3'd0, d); chk_eq("R2 set wins over clear", d, 32'h1);
    wr(3'd0, 32'h1);
    rd(3'd0, d); chk_eq("R2 clear alone", d, 32'h0);

    // R5 alert test pulses
    wr(3'd3, 32'h1);
    chk_eq("R5 recov pulse", {30'h0, alert_recov_o, alert_fatal_o}, 32'h2);
    @(negedge clk);
    chk_eq("R5 recov pulse ends", {30'h0, alert_recov_o, alert_fatal_o}, 32'h0);
    wr(3'd3, 32'h2);
    chk_eq("R5 fatal pulse", {30'h0, alert_recov_o, alert_fatal_o}, 32'h1);
    @(negedge clk);
    chk_eq("R5 fatal pulse ends", {30'h0, alert_recov_o, alert_fatal_o}, 32'h0);

    // R8 / R9 / R10: sweep every value of every field
    for (int f = 0; f < 4; f++) begin
      for (int v = 0; v < 16; v++) begin
        logic [15:0] w;
        w = 16'h9999;
        w[f*4 +: 4] = 4'(v);
        wr(3'd5, {16'h0, w});
        chk_eq("R10 alert on illegal write", {31'h0, alert_recov_o},
               {31'h0, !exp_legal(4'(v))});
        chk_eq("R8 decoded field", {28'h0, ctrl_bool_o}, {28'h0, 4'(v == 6) << f});
        @(negedge clk);
        rd(3'd6, d);
        chk_eq("R9 status bit", d, {28'h0, 4'(!exp_legal(4'(v))) << f});
        if (!exp_legal(4'(v))) begin
          wr(3'd6, 32'h0);
          rd(3'd6, d);
          chk_eq("R9 set wins over W0C", d, {28'h0, 4'b1 << f});
        end
        wr(3'd5, 32'h9999);
        chk_eq("R10 no alert on legal write", {31'h0, alert_recov_o}, 32'h0);
        wr(3'd6, 32'h0);
        rd(3'd6, d); chk_eq("R9 W0C clears", d, 32'h0);
      end
    end
    wr(3'd5, 32'h6666);
    chk_eq("R8 all true", {28'h0, ctrl_bool_o}, 32'hf);

    // R11 bus repeat event
    @(negedge clk); bus_repeat_evt_i = 1'b1;
    @(negedge clk); bus_repeat_evt_i = 1'b0;
    chk_eq("R11 alert", {31'h0, alert_recov_o}, 32'h1);
    rd(3'd6, d); chk_eq("R11 status", d, 32'h1000);
    wr(3'd6, 32'hffffefff);
    rd(3'd6, d); chk_eq("R11 W0C", d, 32'h0);

    // R12 error injection sweep
    for (int k = 0; k < 32; k++) begin
      wr(3'd7, 32'hffffffe0 | 32'(k));
      chk_eq("R12 pulse", err_force_o, 32'h1 << k);
      @(negedge clk);
      chk_eq("R12 pulse one cycle", err_force_o, 32'h0);
      rd(3'd7, d); chk_eq("R12 readback", d, 32'(k));
    end

    // R13 reserved bits
    wr(3'd1, 32'hffffffff);
    rd(3'd1, d); chk_eq("R13 enable width", d, 32'h3);
    wr(3'd1, 32'h0);
    rd(3'd2, d); chk_eq("R13 itest reads 0", d, 32'h0);
    rd(3'd3, d); chk_eq("R13 atest reads 0", d, 32'h0);
    wr(3'd5, 32'hffff9999);
    rd(3'd5, d); chk_eq("R13 ctrl upper", d, 32'h9999);
    wr(3'd0, 32'h3);

    // R6 / R7 lock
    wr(3'd4, 32'h1);
    rd(3'd4, d); chk_eq("R6 write 1 keeps lock", d, 32'h1);
    wr(3'd4, 32'h0);
    rd(3'd4, d); chk_eq("R6 W0C lock", d, 32'h0);
    wr(3'd5, 32'h6666);
    rd(3'd5, d); chk_eq("R7 ctrl locked", d, 32'h9999);
    chk_eq("R7 bools unchanged", {28'h0, ctrl_bool_o}, 32'h0);
    wr(3'd5, 32'h1234);
    chk_eq("R7 no alert when locked", {31'h0, alert_recov_o}, 32'h0);
    wr(3'd4, 32'h1);
    rd(3'd4, d); chk_eq("R6 lock not re-set", d, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule